// File: doc/BRIEF.md
# Parallel Flash Command State Machine

This block is a clocked behavioural model of the command side of a byte-wide parallel NOR flash. Chip enable, write enable and output enable are active low and are sampled on the clock, together with the address and data inputs. The block recognises unlock-prefixed sequences that program one byte, erase a 4 KByte sector, erase a 64 KByte block or erase the whole array. After a sequence is accepted, an internal busy phase runs for a number of clock cycles set by a parameter. During that phase the only data a host can read is a pair of completion status bits.

A small sparse register array stands in for the flash cells so that results can be read back. Its entry index is built from three fields of the byte address: one block-select bit, two sector-select bits and three offset bits. The array starts at all ones. Because it is non-volatile in spirit, reset does not clear it. The array is a simple dual-port memory and can map to block RAM. The engine erases it by sweeping one entry per cycle and programs it with a read-then-write.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, dq_oe is low, no operation is busy and the decoder is idle. Every array entry reads 8'hFF until it is first programmed.
- R2: dq_oe is high in the cycle after a clock edge at which ce_n and oe_n were both sampled low, and low otherwise. When the block is not busy, dq_out then holds the array byte at the address sampled at that edge.
- R3: A bus write is an interval during which ce_n and we_n are both sampled low. The address is captured at the first edge of the interval and the data at the first edge after it ends. A change of address during the interval has no effect.
- R4: Byte program is the write sequence 5555h/AAh, 2AAAh/55h, 5555h/A0h, followed by one write carrying the target address and byte. Command addresses are compared on address bits 15:0.
- R5: Programming only clears bits: the stored byte becomes old AND new.
- R6: Sector erase is 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then any address with data 30h. It sets to FFh every entry whose block-select and sector-select fields equal those of that address.
- R7: Block erase is the same five-write prefix followed by data 50h. It sets to FFh every entry whose block-select field equals that of the final address.
- R8: Chip erase is the same prefix followed by 10h written to address 5555h. It sets the whole array to FFh. Data 10h at any other address starts nothing.
- R9: A write that does not match the next expected step returns the decoder to idle, so the sequence must then restart from its first write.
- R10: Busy lasts exactly max(PROG_CYC,2) cycles for a program and max(ERASE_CYC, array depth) cycles for an erase, counted from the launching edge. Any write that completes while busy is ignored.
- R11: While busy, a read returns bit 7 as the complement of the data byte's bit 7 for a program, or 0 for an erase. Bit 6 inverts at every new read access (oe and ce newly both low), and bits 5:0 are 0.
- R12: The array index is {addr[16], addr[13:12], addr[2:0]}. Addresses that agree in these bits share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dq_out | output | 8 | Read data or busy status |
| dq_oe | output | 1 | Read data valid; bus would be driven |

## Verification
The bench attacks four weak points:
- **Writes landing inside the busy window.** A full second program sequence is issued inside a running program. A design that does not block writes while busy would program a second byte that must stay FFh.
- **Toggle bit.** Reads during busy are split into several separate accesses. A design that flips the toggle bit every cycle, or never flips it, shows the wrong bit 6 on the second access.
- **Broken sequences and command look-alikes.** A corrupted unlock step and a 10h command written to a non-command address are both sent. A forgiving decoder would then program or wipe bytes that must survive.
- **Address moving during a write strobe, and erase scope.** The address changes in the middle of a write strobe. Sector, block and chip erases each clear only their own entries. A design that samples the address late or masks the wrong index fields would clear or write the wrong bytes.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;
  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_BLK, OP_CHIP} op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E3, ST_E4, ST_E5
  } step_e;

  localparam logic [7:0] K_UNLK1 = 8'hAA;
  localparam logic [7:0] K_UNLK2 = 8'h55;
  localparam logic [7:0] K_PGM   = 8'hA0;
  localparam logic [7:0] K_ERS   = 8'h80;
  localparam logic [7:0] K_SECT  = 8'h30;
  localparam logic [7:0] K_BLK   = 8'h50;
  localparam logic [7:0] K_CHIP  = 8'h10;

  localparam logic [15:0] CMD_ADR_A = 16'h5555;
  localparam logic [15:0] CMD_ADR_B = 16'h2AAA;
endpackage

// File: rtl/fcsm_bus_sampler.sv
module fcsm_bus_sampler #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              fire_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o
);
  logic              strobe, strobe_q;
  logic [ADDR_W-1:0] addr_q;

  assign strobe = !ce_n && !we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe && !strobe_q) addr_q <= addr;
    end
  end

  assign fire_o = strobe_q && !strobe;
  assign addr_o = addr_q;
  assign data_o = din;

  // R3: address held through the rest of a strobe
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe && strobe_q) |=> addr_q == $past(addr_q));
endmodule

// File: rtl/fcsm_seq_decoder.sv
module fcsm_seq_decoder
  import fcsm_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int CMD_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  output logic              launch_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] taddr_o,
  output logic [7:0]        tdata_o
);
  localparam logic [CMD_AW-1:0] ADR_A = CMD_AW'(CMD_ADR_A);
  localparam logic [CMD_AW-1:0] ADR_B = CMD_AW'(CMD_ADR_B);

  step_e step_q, step_d;
  logic  at_a, at_b;

  assign at_a = waddr_i[CMD_AW-1:0] == ADR_A;
  assign at_b = waddr_i[CMD_AW-1:0] == ADR_B;

  always_comb begin
    step_d   = step_q;
    launch_o = 1'b0;
    op_o     = OP_PROG;
    if (fire_i && !busy_i) begin
      step_d = ST_IDLE;
      unique case (step_q)
        ST_IDLE: if (at_a && wdata_i == K_UNLK1) step_d = ST_U1;
        ST_U1:   if (at_b && wdata_i == K_UNLK2) step_d = ST_U2;
        ST_U2: begin
          if (at_a && wdata_i == K_PGM)      step_d = ST_PGM;
          else if (at_a && wdata_i == K_ERS) step_d = ST_E3;
        end
        ST_PGM: launch_o = 1'b1;
        ST_E3:  if (at_a && wdata_i == K_UNLK1) step_d = ST_E4;
        ST_E4:  if (at_b && wdata_i == K_UNLK2) step_d = ST_E5;
        ST_E5: begin
          if (wdata_i == K_SECT) begin
            launch_o = 1'b1;
            op_o     = OP_SECT;
          end else if (wdata_i == K_BLK) begin
            launch_o = 1'b1;
            op_o     = OP_BLK;
          end else if (at_a && wdata_i == K_CHIP) begin
            launch_o = 1'b1;
            op_o     = OP_CHIP;
          end
        end
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_d;
  end

  assign taddr_o = waddr_i;
  assign tdata_o = wdata_i;

  // R9: launches only come from a completed final step
  assert_launch_final_R9: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> (step_q == ST_PGM || step_q == ST_E5));
  // R10: decoder holds idle while an operation runs
  assert_idle_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> step_q == ST_IDLE);
endmodule

// File: rtl/fcsm_array.sv
module fcsm_array #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             a_we,
  input  logic [7:0]       a_wdata,
  output logic [7:0]       a_rdata,
  input  logic [IDX_W-1:0] b_idx,
  output logic [7:0]       b_rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    a_rdata <= mem[a_idx];
    if (a_we) mem[a_idx] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_idx];
  end
endmodule

// File: rtl/fcsm_op_engine.sv
module fcsm_op_engine
  import fcsm_pkg::*;
#(
  parameter int OFS_W     = 3,
  parameter int SSEL_W    = 2,
  parameter int BSEL_W    = 1,
  parameter int PROG_LEN  = 2,
  parameter int ERASE_LEN = 64
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            launch_i,
  input  op_e                             op_i,
  input  logic [BSEL_W+SSEL_W+OFS_W-1:0]  tidx_i,
  input  logic [7:0]                      pdata_i,
  output logic                            busy_o,
  output logic                            poll_o,
  output logic [BSEL_W+SSEL_W+OFS_W-1:0]  a_idx_o,
  output logic                            a_we_o,
  output logic [7:0]                      a_wdata_o,
  input  logic [7:0]                      a_rdata_i
);
  localparam int IDX_W  = BSEL_W + SSEL_W + OFS_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int MAXLEN = (PROG_LEN > ERASE_LEN) ? PROG_LEN : ERASE_LEN;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, last_cnt;
  op_e              op_q;
  logic [IDX_W-1:0] tidx_q;
  logic [7:0]       pdata_q;

  logic [IDX_W-1:0]  sweep_idx;
  logic [BSEL_W-1:0] k_b, t_b;
  logic [SSEL_W-1:0] k_s, t_s;
  logic              hit, sweeping;

  assign last_cnt = (op_q == OP_PROG) ? CNT_W'(PROG_LEN - 1) : CNT_W'(ERASE_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      op_q    <= OP_PROG;
      tidx_q  <= '0;
      pdata_q <= '0;
    end else if (launch_i) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      op_q    <= op_i;
      tidx_q  <= tidx_i;
      pdata_q <= pdata_i;
    end else if (busy_q) begin
      if (cnt_q == last_cnt) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sweep_idx = cnt_q[IDX_W-1:0];
  assign sweeping  = busy_q && (cnt_q < CNT_W'(DEPTH));
  assign k_b = sweep_idx[IDX_W-1 -: BSEL_W];
  assign k_s = sweep_idx[OFS_W +: SSEL_W];
  assign t_b = tidx_q[IDX_W-1 -: BSEL_W];
  assign t_s = tidx_q[OFS_W +: SSEL_W];

  always_comb begin
    unique case (op_q)
      OP_CHIP: hit = 1'b1;
      OP_BLK:  hit = (k_b == t_b);
      OP_SECT: hit = (k_b == t_b) && (k_s == t_s);
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    if (op_q == OP_PROG) begin
      a_idx_o   = tidx_q;
      a_we_o    = busy_q && (cnt_q == CNT_W'(1));
      a_wdata_o = a_rdata_i & pdata_q;
    end else begin
      a_idx_o   = sweep_idx;
      a_we_o    = sweeping && hit;
      a_wdata_o = 8'hFF;
    end
  end

  assign busy_o = busy_q;
  assign poll_o = (op_q == OP_PROG) ? ~pdata_q[7] : 1'b0;

  // R10: no launch accepted while an operation is running
  assert_no_relaunch_R10: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && launch_i));
  // R10: busy ends only after the full length for its operation
  assert_busy_len_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_q) && !$past(launch_i)) |-> $past(cnt_q) == $past(last_cnt));
  // R5: a program write never sets a bit that memory held at zero
  assert_clear_only_R5: assert property (@(posedge clk) disable iff (rst)
    (a_we_o && op_q == OP_PROG) |-> (a_wdata_o & ~a_rdata_i) == 8'h00);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fcsm_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int CMD_AW    = 16,
  parameter int SEC_SH    = 12,
  parameter int BLK_SH    = 16,
  parameter int OFS_W     = 3,
  parameter int SSEL_W    = 2,
  parameter int BSEL_W    = 1,
  parameter int PROG_CYC  = 4000,
  parameter int ERASE_CYC = 5000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  localparam int IDX_W     = BSEL_W + SSEL_W + OFS_W;
  localparam int DEPTH     = 1 << IDX_W;
  localparam int PROG_LEN  = (PROG_CYC < 2) ? 2 : PROG_CYC;
  localparam int ERASE_LEN = (ERASE_CYC < DEPTH) ? DEPTH : ERASE_CYC;

  function automatic logic [IDX_W-1:0] to_idx(input logic [ADDR_W-1:0] a);
    return {a[BLK_SH +: BSEL_W], a[SEC_SH +: SSEL_W], a[OFS_W-1:0]};
  endfunction

  logic              fire;
  logic [ADDR_W-1:0] waddr, taddr;
  logic [7:0]        wdata, tdata;
  logic              launch, busy, poll;
  op_e               op;
  logic [IDX_W-1:0]  a_idx;
  logic              a_we;
  logic [7:0]        a_wdata, a_rdata, b_rdata;
  logic              unused_taddr_bits;

  assign unused_taddr_bits = ^taddr;

  fcsm_bus_sampler #(.ADDR_W(ADDR_W)) u_sampler (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .fire_o(fire), .addr_o(waddr), .data_o(wdata)
  );

  fcsm_seq_decoder #(.ADDR_W(ADDR_W), .CMD_AW(CMD_AW)) u_decoder (
    .clk(clk), .rst(rst), .busy_i(busy), .fire_i(fire), .waddr_i(waddr),
    .wdata_i(wdata), .launch_o(launch), .op_o(op), .taddr_o(taddr), .tdata_o(tdata)
  );

  fcsm_op_engine #(
    .OFS_W(OFS_W), .SSEL_W(SSEL_W), .BSEL_W(BSEL_W),
    .PROG_LEN(PROG_LEN), .ERASE_LEN(ERASE_LEN)
  ) u_engine (
    .clk(clk), .rst(rst), .launch_i(launch), .op_i(op), .tidx_i(to_idx(taddr)),
    .pdata_i(tdata), .busy_o(busy), .poll_o(poll), .a_idx_o(a_idx),
    .a_we_o(a_we), .a_wdata_o(a_wdata), .a_rdata_i(a_rdata)
  );

  fcsm_array #(.IDX_W(IDX_W)) u_array (
    .clk(clk), .a_idx(a_idx), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_idx(to_idx(addr)), .b_rdata(b_rdata)
  );

  // read path
  logic       rd_act, rd_prev_q, rd_start, tgl_q, tgl_next;
  logic       oe_q, show_stat_q;
  logic [7:0] stat_q;

  assign rd_act   = !ce_n && !oe_n;
  assign rd_start = rd_act && !rd_prev_q;
  assign tgl_next = tgl_q ^ (busy && rd_start);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev_q   <= 1'b0;
      tgl_q       <= 1'b0;
      oe_q        <= 1'b0;
      show_stat_q <= 1'b0;
      stat_q      <= '0;
    end else begin
      rd_prev_q   <= rd_act;
      tgl_q       <= tgl_next;
      oe_q        <= rd_act;
      show_stat_q <= busy;
      stat_q      <= {poll, tgl_next, 6'b0};
    end
  end

  assign dq_oe  = oe_q;
  assign dq_out = show_stat_q ? stat_q : b_rdata;

  // R2: output enable follows a sampled read one cycle later
  assert_oe_on_R2: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n) |=> dq_oe);
  assert_oe_off_R2: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n) |=> !dq_oe);
  // R11: status byte carries zeros in its low six bits
  assert_stat_low_R11: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && show_stat_q) |-> dq_out[5:0] == 6'b0);
  // R11: toggle bit inverts on each new read access while busy
  assert_toggle_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_start) |=> tgl_q != $past(tgl_q));
endmodule

// File: tb/tb_flash_cmd_fsm.sv
`timescale 1ns/1ps
module tb_flash_cmd_fsm;
  localparam int AW = 21;
  localparam int PC = 20;
  localparam int EC = 100;
  localparam int DEPTH = 64;
  localparam int PLEN = 20;
  localparam int ELEN = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dq_out;
  logic dq_oe;

  flash_cmd_fsm #(.ADDR_W(AW), .PROG_CYC(PC), .ERASE_CYC(EC)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string ctx = "R1";

  // reference model state
  int m_mem [DEPTH];
  bit m_busy, m_wprev, m_rprev, m_tgl;
  int m_cnt, m_len, m_op, m_tidx, m_step;
  logic [7:0] m_pd;
  logic [AW-1:0] m_alat;
  bit e_oe;
  logic [7:0] e_dq;
  string e_tag = "R2";

  function automatic int idx_of(logic [AW-1:0] a);
    return 32 * int'(a[16]) + 8 * int'(a[13:12]) + int'(a[2:0]);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_launch(int op, logic [AW-1:0] a, logic [7:0] d);
    m_busy = 1; m_cnt = 0; m_op = op; m_tidx = idx_of(a); m_pd = d;
    m_len = (op == 0) ? PLEN : ELEN;
  endtask

  task automatic m_apply();
    int tb_, ts_;
    tb_ = m_tidx / 32; ts_ = (m_tidx / 8) % 4;
    if (m_op == 0) m_mem[m_tidx] = m_mem[m_tidx] & int'(m_pd);
    else for (int k = 0; k < DEPTH; k++) begin
      if (m_op == 3 || (m_op == 2 && k / 32 == tb_) ||
          (m_op == 1 && k / 32 == tb_ && (k / 8) % 4 == ts_)) m_mem[k] = 255;
    end
  endtask

  task automatic m_decode(logic [AW-1:0] a, logic [7:0] d);
    logic [15:0] c;
    int nxt;
    c = a[15:0];
    nxt = 0;
    case (m_step)
      0: if (c == 16'h5555 && d == 8'hAA) nxt = 1;
      1: if (c == 16'h2AAA && d == 8'h55) nxt = 2;
      2: if (c == 16'h5555 && d == 8'hA0) nxt = 3;
         else if (c == 16'h5555 && d == 8'h80) nxt = 4;
      3: m_launch(0, a, d);
      4: if (c == 16'h5555 && d == 8'hAA) nxt = 5;
      5: if (c == 16'h2AAA && d == 8'h55) nxt = 6;
      6: if (d == 8'h30) m_launch(1, a, d);
         else if (d == 8'h50) m_launch(2, a, d);
         else if (c == 16'h5555 && d == 8'h10) m_launch(3, a, d);
      default: nxt = 0;
    endcase
    m_step = nxt;
  endtask

  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;

  always @(posedge clk) begin : model
    bit rd, wr, rs, bpre;
    if (rst) begin
      m_busy = 0; m_step = 0; m_wprev = 0; m_rprev = 0; m_tgl = 0; e_oe = 0;
    end else begin
      rd = !ce_n && !oe_n;
      wr = !ce_n && !we_n;
      rs = rd && !m_rprev;
      bpre = m_busy;
      e_oe = rd;
      if (rd) begin
        if (bpre) begin
          if (rs) m_tgl = !m_tgl;
          e_dq = {(m_op == 0) ? ~m_pd[7] : 1'b0, m_tgl, 6'b0};
          e_tag = "R11";
        end else begin
          e_dq = 8'(m_mem[idx_of(addr)]);
          e_tag = ctx;
        end
      end
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == m_len) begin m_apply(); m_busy = 0; end
      end
      if (wr && !m_wprev) m_alat = addr;
      if (!wr && m_wprev && !bpre) m_decode(m_alat, din);
      m_wprev = wr;
      m_rprev = rd;
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2", {7'b0, dq_oe}, {7'b0, e_oe});
      if (e_oe && dq_oe) check(e_tag, dq_out, e_dq);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    cyc(2); we_n = 1; ce_n = 1;
    cyc(1);
  endtask

  task automatic wr_move(logic [AW-1:0] a, logic [AW-1:0] a2, logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    cyc(1); addr = a2;
    cyc(1); we_n = 1; ce_n = 1;
    cyc(1);
  endtask

  task automatic rd(logic [AW-1:0] a, int n);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    cyc(n); oe_n = 1; ce_n = 1;
    cyc(1);
  endtask

  task automatic prog(logic [AW-1:0] a, logic [7:0] d);
    wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(21'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic erase6(logic [AW-1:0] a, logic [7:0] d);
    wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(21'h05555, 8'h80);
    wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(a, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    cyc(3);
    check("R1", {7'b0, dq_oe}, 8'h00);  // R1: no read output during reset
    rst = 0;
    cyc(2);
    ctx = "R1";  rd(21'h00000, 2); rd(21'h10007, 1);   // R1: array starts at FF

    ctx = "R4";  prog(21'h00001, 8'h3C);
    rd(21'h00001, 3); rd(21'h00001, 1); rd(21'h00002, 1);  // R11 status, toggles per access
    cyc(PLEN);
    rd(21'h00001, 2);                                   // R4: programmed value

    ctx = "R5";  prog(21'h00001, 8'hF0); cyc(PLEN + 2);
    rd(21'h00001, 1);                                   // R5: 3C & F0 = 30

    ctx = "R10"; prog(21'h00002, 8'h55);
    prog(21'h00003, 8'h00);                             // R10: issued while busy
    cyc(PLEN);
    rd(21'h00003, 1); rd(21'h00002, 1);
    erase6(21'h10000, 8'h50);
    erase6(21'h00000, 8'h30);                           // R10: erase during erase ignored
    rd(21'h00001, 2);
    cyc(ELEN);
    rd(21'h00001, 1); rd(21'h00002, 1);

    ctx = "R9";  wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h54);
    wr(21'h05555, 8'hA0); wr(21'h00004, 8'h00);         // R9: broken prefix
    cyc(PLEN); rd(21'h00004, 1);

    ctx = "R3";  wr(21'h05555, 8'hAA); wr(21'h02AAA, 8'h55); wr(21'h05555, 8'hA0);
    wr_move(21'h00005, 21'h00006, 8'h12);               // R3: address captured early
    cyc(PLEN); rd(21'h00005, 1); rd(21'h00006, 1);

    ctx = "R12"; prog(21'h01003, 8'h11); cyc(PLEN);
    prog(21'h10003, 8'h22); cyc(PLEN);
    prog(21'h02003, 8'h33); cyc(PLEN);
    prog(21'h11002, 8'h44); cyc(PLEN);
    rd(21'h01003, 1); rd(21'h10003, 1); rd(21'h02003, 1); rd(21'h11002, 1);
    rd(21'h41003, 1);                                   // R12: alias of 01003

    ctx = "R6";  erase6(21'h01000, 8'h30);
    rd(21'h01003, 4);                                   // status with poll 0
    cyc(ELEN);
    rd(21'h01003, 1); rd(21'h02003, 1); rd(21'h00001, 1);

    ctx = "R7";  erase6(21'h10000, 8'h50); cyc(ELEN + 2);
    rd(21'h11002, 1); rd(21'h10003, 1); rd(21'h02003, 1);

    ctx = "R8";  erase6(21'h01234, 8'h10); cyc(ELEN);  // R8: not at 5555h
    rd(21'h02003, 1); rd(21'h00001, 1);
    erase6(21'h05555, 8'h10); cyc(ELEN + 2);
    rd(21'h02003, 1); rd(21'h00001, 1); rd(21'h00005, 1);

    cyc(4);
    finish_run();
  end
endmodule